// File: doc/BRIEF.md
# Host Serial Link to Packet Network Bridge

This block connects a host computer's asynchronous serial line to the local port of an on-chip packet network. It does not know the host's bit rate in advance. After reset, the host sends one calibration byte of value 55H. The bridge times that byte's falling edges, derives the bit period from them, and from then on uses that period for both serial directions.

Once calibrated, the bridge reads short command messages from the host and turns each one into one or more fixed-format network packets. A read or write of several words produces one packet per word, because packets never carry a burst. In the other direction, the bridge accepts packets from the network and converts them into bytes for the host. Console-style output and input-request packets are marked for the host by four 55H bytes followed by the sender's address.

Both packet interfaces are byte-wide valid/ready streams, and a byte moves on a clock edge where valid and ready are both high. The bridge keeps `pkt_out_valid_o` high, and `pkt_out_data_o` unchanged, until the flit is taken. The network side may hold `pkt_in_valid_i` and `pkt_in_data_i` for as long as it likes. The bridge lowers `pkt_in_ready_o` while the serial transmitter is busy or while an escape prefix is being sent.

Top module: `hostlink_bridge`

## Requirements
- R1: Until calibration completes, `locked_o` is 0, `pkt_out_valid_o` is 0, `pkt_in_ready_o` is 0 and `host_tx_o` stays high.
- R2: The bit period is the number of clocks from the first to the fifth falling edge of the 55H calibration byte, divided by eight with rounding. `locked_o` then rises and never falls again until reset.
- R3: Both serial directions use an idle-high line, one low start bit, eight data bits sent least significant bit first, and one high stop bit, each bit lasting one measured period.
- R4: A host read message is 00H, target, count n, address high byte, address low byte. It yields n packets, each `[target, 04H, SRC_ADDR, 00H, addrH, addrL]`. The address increases by one per packet and wraps from FFFFH to 0000H. A count of 0 yields no packet.
- R5: A host write message is 01H, target, n, address high, address low, then n data words as high byte and low byte. It yields n packets `[target, 06H, SRC_ADDR, 01H, addrH, addrL, dataH, dataL]`, with the address increasing by one per word.
- R6: A host activate message is 02H, target. It yields `[target, 02H, SRC_ADDR, 02H]`.
- R7: A host input-reply message is 04H, target, data high, data low. It yields `[target, 04H, SRC_ADDR, 04H, dataH, dataL]`.
- R8: A host byte other than 00H, 01H, 02H or 04H, received where a command is expected, is dropped. No packet follows from it, and the next byte is again taken as a command.
- R9: While `pkt_out_valid_o` is high and `pkt_out_ready_i` is low, valid stays high and the data does not change.
- R10: An incoming packet whose fourth flit is 03H (console output) makes the bridge send the host 55H four times, then the packet's third flit (source address), then every flit after the fourth.
- R11: An incoming packet whose fourth flit is 04H (input request) is sent to the host in the same way as R10: four 55H bytes, the source address, then any flits after the fourth.
- R12: An incoming packet whose fourth flit is 09H (read reply) sends to the host only the flits after the fourth.
- R13: An incoming packet with any other fourth-flit value is consumed completely and sends nothing to the host. Packet length is always the second flit plus two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rx_i | input | 1 | Serial line from the host |
| host_tx_o | output | 1 | Serial line to the host |
| locked_o | output | 1 | Bit period has been measured |
| pkt_out_valid_o | output | 1 | Outgoing flit is valid |
| pkt_out_ready_i | input | 1 | Network accepts the outgoing flit |
| pkt_out_data_o | output | 8 | Outgoing flit |
| pkt_in_valid_i | input | 1 | Incoming flit is valid |
| pkt_in_ready_o | output | 1 | Bridge accepts the incoming flit |
| pkt_in_data_i | input | 8 | Incoming flit |

## Verification
The two directions are independent, so a host command can be arriving on the receive line in the same cycles that the escape prefix and payload of a console-output packet are leaving on the transmit line. The bench provokes this by running the serial sender and the network sender in parallel branches. It does so during a write message and again during a sweep over source addresses. It then judges both sides separately: the exact flit sequence captured from the outgoing stream under a stalling ready pattern, and the exact byte sequence decoded from the host line, with its stop bits checked.

// File: rtl/hlb_pkg.sv
package hlb_pkg;
  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_WRITE = 8'h01;
  localparam logic [7:0] CMD_ACT   = 8'h02;
  localparam logic [7:0] CMD_PRINT = 8'h03;
  localparam logic [7:0] CMD_SCAN  = 8'h04;
  localparam logic [7:0] CMD_RDRET = 8'h09;
  localparam logic [7:0] ESC_BYTE  = 8'h55;
  localparam int unsigned ESC_LEN  = 5;   // four markers plus source address

  typedef enum logic [2:0] {
    P_CMD, P_TGT, P_CNT, P_AH, P_AL, P_DH, P_DL, P_SEND
  } pstate_t;
endpackage

// File: rtl/hlb_autobaud.sv
module hlb_autobaud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  output logic [DIV_W-1:0] period_o,
  output logic             locked_o
);
  localparam int SPAN_W = DIV_W + 3;

  logic [SPAN_W-1:0] span;
  logic [1:0]        falls;
  logic              run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span     <= '0;
      falls    <= '0;
      run      <= 1'b0;
      locked_o <= 1'b0;
      period_o <= '0;
    end else if (!locked_o) begin
      if (run) span <= span + SPAN_W'(1);
      if (fall_i) begin
        if (!run) begin
          run  <= 1'b1;
          span <= SPAN_W'(1);
        end else if (falls == 2'd3) begin
          locked_o <= 1'b1;
          period_o <= DIV_W'((span + SPAN_W'(4)) >> 3);
        end else begin
          falls <= falls + 2'd1;
        end
      end
    end
  end

  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(locked_o));
  assert_period_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> period_o != '0);
endmodule

// File: rtl/hlb_uart_rx.sv
module hlb_uart_rx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             line_i,
  input  logic             fall_i,
  input  logic [DIV_W-1:0] period_i,
  output logic [7:0]       byte_o,
  output logic             valid_o
);
  logic             busy;
  logic [3:0]       bitn;
  logic [DIV_W-1:0] tmr;
  logic [7:0]       sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; bitn <= '0; tmr <= '0; sh <= '0;
      byte_o <= '0; valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!busy) begin
        if (en_i && fall_i) begin
          busy <= 1'b1;
          bitn <= '0;
          tmr  <= period_i >> 1;
        end
      end else if (tmr != '0) begin
        tmr <= tmr - DIV_W'(1);
      end else begin
        tmr <= period_i - DIV_W'(1);
        if (bitn == 4'd0) begin
          if (line_i) busy <= 1'b0;       // glitch, not a start bit
          bitn <= 4'd1;
        end else if (bitn == 4'd9) begin
          busy    <= 1'b0;
          valid_o <= line_i;              // framing error drops the byte
          byte_o  <= sh;
        end else begin
          sh   <= {line_i, sh[7:1]};
          bitn <= bitn + 4'd1;
        end
      end
    end
  end

  assert_rx_after_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> en_i);
endmodule

// File: rtl/hlb_uart_tx.sv
module hlb_uart_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] period_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic             ready_o,
  output logic             line_o
);
  logic             busy;
  logic [9:0]       sh;
  logic [3:0]       left;
  logic [DIV_W-1:0] tmr;

  assign ready_o = en_i && !busy;
  assign line_o  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sh <= '1; left <= '0; tmr <= '0;
    end else if (!busy) begin
      if (valid_i && ready_o) begin
        busy <= 1'b1;
        sh   <= {1'b1, data_i, 1'b0};
        left <= 4'd10;
        tmr  <= period_i - DIV_W'(1);
      end
    end else if (tmr != '0) begin
      tmr <= tmr - DIV_W'(1);
    end else if (left == 4'd1) begin
      busy <= 1'b0;
    end else begin
      sh   <= {1'b1, sh[9:1]};
      left <= left - 4'd1;
      tmr  <= period_i - DIV_W'(1);
    end
  end

  assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> !line_o);
endmodule

// File: rtl/hlb_pkt_builder.sv
module hlb_pkt_builder
  import hlb_pkg::*;
#(
  parameter logic [7:0] SRC_ADDR = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_i,
  input  logic       bvalid_i,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic [7:0] out_data_o
);
  pstate_t     st;
  logic [7:0]  cmd, tgt, cnt, dh, dl;
  logic [15:0] addr;
  logic [2:0]  fidx;
  logic [3:0]  nflits;

  always_comb begin
    unique case (cmd)
      CMD_READ:  nflits = 4'd6;
      CMD_WRITE: nflits = 4'd8;
      CMD_ACT:   nflits = 4'd4;
      default:   nflits = 4'd6;   // input reply
    endcase
  end

  assign out_valid_o = (st == P_SEND);

  always_comb begin
    unique case (fidx)
      3'd0: out_data_o = tgt;
      3'd1: out_data_o = {4'd0, nflits} - 8'd2;
      3'd2: out_data_o = SRC_ADDR;
      3'd3: out_data_o = cmd;
      3'd4: out_data_o = (cmd == CMD_SCAN) ? dh : addr[15:8];
      3'd5: out_data_o = (cmd == CMD_SCAN) ? dl : addr[7:0];
      3'd6: out_data_o = dh;
      default: out_data_o = dl;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= P_CMD; cmd <= '0; tgt <= '0; cnt <= '0;
      dh <= '0; dl <= '0; addr <= '0; fidx <= '0;
    end else begin
      unique case (st)
        P_CMD: if (bvalid_i) begin
          cmd <= byte_i;
          if (byte_i == CMD_READ || byte_i == CMD_WRITE ||
              byte_i == CMD_ACT  || byte_i == CMD_SCAN) st <= P_TGT;
        end
        P_TGT: if (bvalid_i) begin
          tgt <= byte_i;
          st  <= (cmd == CMD_ACT) ? P_SEND : (cmd == CMD_SCAN) ? P_DH : P_CNT;
        end
        P_CNT: if (bvalid_i) begin cnt <= byte_i; st <= P_AH; end
        P_AH:  if (bvalid_i) begin addr[15:8] <= byte_i; st <= P_AL; end
        P_AL:  if (bvalid_i) begin
          addr[7:0] <= byte_i;
          st <= (cnt == '0) ? P_CMD : (cmd == CMD_READ) ? P_SEND : P_DH;
        end
        P_DH:  if (bvalid_i) begin dh <= byte_i; st <= P_DL; end
        P_DL:  if (bvalid_i) begin dl <= byte_i; st <= P_SEND; end
        default: if (out_ready_i) begin
          if ({1'b0, fidx} == nflits - 4'd1) begin
            fidx <= '0;
            if (cmd == CMD_READ || cmd == CMD_WRITE) begin
              cnt  <= cnt - 8'd1;
              addr <= addr + 16'd1;
              st   <= (cnt == 8'd1) ? P_CMD : (cmd == CMD_READ) ? P_SEND : P_DH;
            end else begin
              st <= P_CMD;
            end
          end else begin
            fidx <= fidx + 3'd1;
          end
        end
      endcase
    end
  end

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: rtl/hlb_pkt_splitter.sv
module hlb_pkt_splitter
  import hlb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [7:0] in_data_i,
  output logic       tb_valid_o,
  input  logic       tb_ready_i,
  output logic [7:0] tb_data_o
);
  logic [8:0] fidx;
  logic [7:0] len_q, src_q, cmd_q, eff_len;
  logic [2:0] esc;
  logic       fwd, last, take;

  assign eff_len = (fidx == 9'd1) ? in_data_i : len_q;
  assign last    = (fidx != 9'd0) && (fidx == {1'b0, eff_len} + 9'd1);
  assign fwd     = (fidx >= 9'd4) &&
                   (cmd_q == CMD_PRINT || cmd_q == CMD_SCAN || cmd_q == CMD_RDRET);
  assign take    = in_valid_i && in_ready_o;

  always_comb begin
    if (esc != '0) begin
      tb_valid_o = 1'b1;
      tb_data_o  = (esc > 3'd1) ? ESC_BYTE : src_q;
      in_ready_o = 1'b0;
    end else if (fwd) begin
      tb_valid_o = in_valid_i && en_i;
      tb_data_o  = in_data_i;
      in_ready_o = tb_ready_i;
    end else begin
      tb_valid_o = 1'b0;
      tb_data_o  = in_data_i;
      in_ready_o = en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fidx <= '0; len_q <= '0; src_q <= '0; cmd_q <= '0; esc <= '0;
    end else begin
      if (esc != '0 && tb_ready_i) esc <= esc - 3'd1;
      if (take) begin
        fidx <= last ? 9'd0 : fidx + 9'd1;
        if (fidx == 9'd1) len_q <= in_data_i;
        if (fidx == 9'd2) src_q <= in_data_i;
        if (fidx == 9'd3) begin
          cmd_q <= in_data_i;
          if (in_data_i == CMD_PRINT || in_data_i == CMD_SCAN) esc <= 3'(ESC_LEN);
        end
      end
    end
  end

  assert_escape_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fidx == 9'd3 && in_data_i == CMD_PRINT) |=> (tb_valid_o && tb_data_o == ESC_BYTE));
endmodule

// File: rtl/hostlink_bridge.sv
module hostlink_bridge #(
  parameter logic [7:0] SRC_ADDR = 8'h00,
  parameter int         DIV_W    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_rx_i,
  output logic       host_tx_o,
  output logic       locked_o,
  output logic       pkt_out_valid_o,
  input  logic       pkt_out_ready_i,
  output logic [7:0] pkt_out_data_o,
  input  logic       pkt_in_valid_i,
  output logic       pkt_in_ready_o,
  input  logic [7:0] pkt_in_data_i
);
  logic [2:0]       sync;
  logic             line, fall;
  logic [DIV_W-1:0] period;
  logic [7:0]       rx_byte, tb_data;
  logic             rx_valid, tb_valid, tb_ready, bvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[1:0], host_rx_i};
  end
  assign line = sync[1];
  assign fall = sync[2] & ~sync[1];

  hlb_autobaud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .fall_i(fall), .period_o(period), .locked_o(locked_o));

  hlb_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(locked_o), .line_i(line), .fall_i(fall),
    .period_i(period), .byte_o(rx_byte), .valid_o(rx_valid));

  // bytes that land while a packet is being emitted are dropped
  assign bvalid = rx_valid && !pkt_out_valid_o;

  hlb_pkt_builder #(.SRC_ADDR(SRC_ADDR)) u_build (
    .clk(clk), .rst_n(rst_n), .byte_i(rx_byte), .bvalid_i(bvalid),
    .out_valid_o(pkt_out_valid_o), .out_ready_i(pkt_out_ready_i),
    .out_data_o(pkt_out_data_o));

  hlb_pkt_splitter u_split (
    .clk(clk), .rst_n(rst_n), .en_i(locked_o),
    .in_valid_i(pkt_in_valid_i), .in_ready_o(pkt_in_ready_o), .in_data_i(pkt_in_data_i),
    .tb_valid_o(tb_valid), .tb_ready_i(tb_ready), .tb_data_o(tb_data));

  hlb_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en_i(locked_o), .period_i(period),
    .valid_i(tb_valid), .data_i(tb_data), .ready_o(tb_ready), .line_o(host_tx_o));

  assert_quiet_before_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> (!pkt_out_valid_o && !pkt_in_ready_o && host_tx_o));
endmodule

// File: tb/test_hostlink_bridge.sv
module test_hostlink_bridge;
  localparam int BP = 16;
  localparam logic [7:0] SRC = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0, host_rx = 1'b1;
  logic host_tx, locked, out_v, out_r, in_v, in_r;
  logic [7:0] out_d, in_d;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit bp_on = 1'b0, done = 1'b0;
  logic [7:0] pkt_q[$];
  logic [7:0] host_q[$];

  always #5 clk = ~clk;

  hostlink_bridge #(.SRC_ADDR(SRC), .DIV_W(16)) i_hostlink_bridge (
    .clk(clk), .rst_n(rst_n), .host_rx_i(host_rx), .host_tx_o(host_tx),
    .locked_o(locked), .pkt_out_valid_o(out_v), .pkt_out_ready_i(out_r),
    .pkt_out_data_o(out_d), .pkt_in_valid_i(in_v), .pkt_in_ready_o(in_r),
    .pkt_in_data_i(in_d));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // outgoing stream sink with optional stall pattern (R9)
  initial begin
    out_r = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      out_r = bp_on ? (cyc % 3 != 0) : 1'b1;
      if (out_v && out_r) pkt_q.push_back(out_d);
    end
  end

  // host-side serial receiver, checks stop bit (R3)
  initial begin
    forever begin
      logic [7:0] b;
      @(negedge clk);
      if (rst_n && locked && host_tx == 1'b0) begin
        repeat (BP / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (BP) @(negedge clk);
          b[i] = host_tx;
        end
        repeat (BP) @(negedge clk);
        chk("R3 stop bit", host_tx, 1);
        host_q.push_back(b);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  task automatic host_send(input logic [7:0] b);
    logic [9:0] fr = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); host_rx = fr[i];
      repeat (BP - 1) @(negedge clk);
    end
  endtask

  task automatic flit_send(input logic [7:0] b);
    @(negedge clk); in_v = 1'b1; in_d = b;
    #1;
    while (!in_r) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); in_v = 1'b0;
  endtask

  task automatic expect_q(input string req, ref logic [7:0] q[$], input logic [7:0] e[$]);
    chk({req, " length"}, q.size(), e.size());
    for (int i = 0; i < e.size() && i < q.size(); i++) chk(req, q[i], e[i]);
    q.delete();
  endtask

  initial begin
    in_v = 1'b0; in_d = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet before calibration, even with a flit offered
    @(negedge clk);
    chk("R1 locked", locked, 0);
    chk("R1 tx idle", host_tx, 1);
    chk("R1 out valid", out_v, 0);
    in_v = 1'b1; in_d = 8'h00;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); seen += in_r; end
      chk("R1 in ready", seen, 0);
    end
    in_v = 1'b0;
    // R2: calibration
    host_send(8'h55);
    repeat (20) @(negedge clk);
    chk("R2 locked", locked, 1);
    // R6: activate sweep over targets
    for (int t = 0; t < 16; t++) begin
      host_send(8'h02); host_send(8'(t * 17));
      repeat (60) @(negedge clk);
      expect_q("R6 activate", pkt_q, '{8'(t * 17), 8'h02, SRC, 8'h02});
    end
    // R4: read with wrap, under stalls
    bp_on = 1'b1;
    host_send(8'h00); host_send(8'h05); host_send(8'h03); host_send(8'hFF); host_send(8'hFE);
    repeat (120) @(negedge clk);
    expect_q("R4 read", pkt_q, '{8'h05, 8'h04, SRC, 8'h00, 8'hFF, 8'hFE,
                                 8'h05, 8'h04, SRC, 8'h00, 8'hFF, 8'hFF,
                                 8'h05, 8'h04, SRC, 8'h00, 8'h00, 8'h00});
    // R4: zero count, then activate still parsed
    host_send(8'h00); host_send(8'h01); host_send(8'h00); host_send(8'h12); host_send(8'h34);
    host_send(8'h02); host_send(8'h07);
    repeat (60) @(negedge clk);
    expect_q("R4 zero count", pkt_q, '{8'h07, 8'h02, SRC, 8'h02});
    // R7: input reply
    host_send(8'h04); host_send(8'h06); host_send(8'hBE); host_send(8'hEF);
    repeat (60) @(negedge clk);
    expect_q("R7 reply", pkt_q, '{8'h06, 8'h04, SRC, 8'h04, 8'hBE, 8'hEF});
    // R8: unknown commands dropped
    host_send(8'h07); host_send(8'hFF); host_send(8'h03);
    repeat (40) @(negedge clk);
    chk("R8 no packet", pkt_q.size(), 0);
    host_send(8'h02); host_send(8'h09);
    repeat (60) @(negedge clk);
    expect_q("R8 resync", pkt_q, '{8'h09, 8'h02, SRC, 8'h02});
    // R5 + R10 concurrently
    fork
      begin
        host_send(8'h01); host_send(8'h03); host_send(8'h02); host_send(8'h00); host_send(8'h10);
        host_send(8'h12); host_send(8'h34); host_send(8'hAB); host_send(8'hCD);
      end
      begin
        flit_send(SRC); flit_send(8'h04); flit_send(8'h02); flit_send(8'h03);
        flit_send(8'h12); flit_send(8'h34);
      end
    join
    repeat (1400) @(negedge clk);
    expect_q("R5 write", pkt_q, '{8'h03, 8'h06, SRC, 8'h01, 8'h00, 8'h10, 8'h12, 8'h34,
                                  8'h03, 8'h06, SRC, 8'h01, 8'h00, 8'h11, 8'hAB, 8'hCD});
    expect_q("R10 printf", host_q, '{8'h55, 8'h55, 8'h55, 8'h55, 8'h02, 8'h12, 8'h34});
    // R10 sweep over source addresses, alongside host activates
    for (int s = 0; s < 4; s++) begin
      fork
        begin host_send(8'h02); host_send(8'(s)); end
        begin
          flit_send(SRC); flit_send(8'h03); flit_send(8'(s + 1)); flit_send(8'h03);
          flit_send(8'(s * 3));
        end
      join
      repeat (1200) @(negedge clk);
      expect_q("R10 sweep host", host_q, '{8'h55, 8'h55, 8'h55, 8'h55, 8'(s + 1), 8'(s * 3)});
      expect_q("R6 with printf", pkt_q, '{8'(s), 8'h02, SRC, 8'h02});
    end
    // R11: input request
    flit_send(SRC); flit_send(8'h02); flit_send(8'h01); flit_send(8'h04);
    repeat (1000) @(negedge clk);
    expect_q("R11 scanf", host_q, '{8'h55, 8'h55, 8'h55, 8'h55, 8'h01});
    // R13: other command consumed silently, then R12 read reply
    flit_send(SRC); flit_send(8'h03); flit_send(8'h01); flit_send(8'h08); flit_send(8'h77);
    repeat (400) @(negedge clk);
    chk("R13 silent", host_q.size(), 0);
    flit_send(SRC); flit_send(8'h04); flit_send(8'h01); flit_send(8'h09);
    flit_send(8'hAB); flit_send(8'hCD);
    repeat (600) @(negedge clk);
    expect_q("R12 read reply", host_q, '{8'hAB, 8'hCD});
    chk("R2 still locked", locked, 1);
    finish_run();
  end
endmodule